// File: doc/BRIEF.md
# Periodic Interrupt Timebase Generator

This block raises a periodic interrupt by running a free-running binary counter from an incoming clock and watching one of eight selectable counter bits. A 3-bit rate code chooses the tap, which gives divide ratios from 8 up to 32768. An optional fixed divide-by-128 stage can sit in front of the counter, which stretches every period by the same factor.

Software-facing control is kept to plain level and strobe inputs. These are a run enable, an interrupt enable, the rate code, an acknowledge write strobe with its data bit, and the pre-divide option. When the selected tap rolls over, a sticky event flag is set. The interrupt request is the flag qualified by the interrupt enable. During stop mode the counter freezes unless the oscillator keep-alive option is set. With that option the block keeps counting, so its interrupt can act as a wakeup request.

Top module: `periodic_tick_gen`

## Requirements
- R1: After reset, eventFlag, irqReq and wakeReq are all 0.
- R2: While tickEn is 0 the divider chain and the pre-divider are held at zero, so re-enabling always restarts the half-period first event.
- R3: The rate code selects the division 2^n as follows: 0→32768, 1→8192, 2→2048, 3→128, 4→64, 5→32, 6→16, 7→8. With preDiv=0, eventFlag first reads 1 exactly 2^(n-1) clock edges after tickEn rises.
- R4: After the first event, later events come exactly 2^n counter advances apart.
- R5: With preDiv=1 the counter advances once every 128 clocks, so the first event comes after 128·2^(n-1) clocks.
- R6: irqReq is 1 exactly when eventFlag is 1 and irqEn is 1.
- R7: eventFlag stays set until an edge with ackWr=1 and ackVal=1 clears it. A write with ackVal=0 leaves it unchanged.
- R8: When a tap event and a clearing acknowledge fall on the same edge, eventFlag ends up 1.
- R9: With stopMode=1 and oscInStop=0 the counter freezes and no events occur. Counting resumes where it stopped once stopMode returns to 0.
- R10: With stopMode=1 and oscInStop=1 counting continues, and wakeReq is 1 whenever irqReq is 1 during stop mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase source clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tickEn | input | 1 | Run enable; 0 clears the counter |
| irqEn | input | 1 | Interrupt request enable |
| rateSel | input | 3 | Tap select code (see R3) |
| preDiv | input | 1 | Insert divide-by-128 ahead of the chain |
| ackWr | input | 1 | Acknowledge write strobe |
| ackVal | input | 1 | Data bit of the acknowledge write; 1 clears the flag |
| stopMode | input | 1 | Low-power stop indication |
| oscInStop | input | 1 | Keep counting during stop |
| eventFlag | output | 1 | Sticky tap event flag |
| irqReq | output | 1 | Interrupt request |
| wakeReq | output | 1 | Wakeup request during stop mode |

## Verification
The hardest case to reach is an acknowledge that lands on the same edge as a fresh tap event. Reaching it needs an exact count of edges from the previous event. The stimulus uses the shortest rate (divide by 8). It clears the flag right after the first event and then counts seven more edges before raising the acknowledge. That puts the write on the edge where the next event registers. The long taps and the pre-divided taps are covered by a measured first-event latency and period from the vector table, so every ratio is checked against its expected count of edges.

// File: rtl/ptg_pkg.sv
package ptg_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic run;    // advance the divider this cycle
    logic clear;  // force divider to zero
  } ctl_strobe_t;

  // Counter bit whose 0->1 transition marks an event for a divide by 2^n (bit n-1)
  function automatic int tapIndex(input logic [2:0] sel);
    case (sel)
      3'd0:    return 14;
      3'd1:    return 12;
      3'd2:    return 10;
      3'd3:    return 6;
      3'd4:    return 5;
      3'd5:    return 4;
      3'd6:    return 3;
      default: return 2;
    endcase
  endfunction

endpackage

// File: rtl/ptg_datapath.sv
module ptg_datapath
  import ptg_pkg::*;
#(
  parameter int CHAIN_W = 15,
  parameter int PRE_W   = 7
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctl_strobe_t strobes,
  input  logic        preDiv,
  input  logic [2:0]  rateSel,
  output logic        tapEvent
);

  localparam int TAP_W = $clog2(CHAIN_W);

  logic               advance;
  logic [CHAIN_W-1:0] chainCnt;
  logic [CHAIN_W-1:0] chainNext;
  logic [TAP_W-1:0]   tapIdx;

  generate
    if (PRE_W > 0) begin : g_prescale
      localparam logic [PRE_W-1:0] PRE_MAX = '1;
      logic [PRE_W-1:0] preCnt;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                          preCnt <= '0;
        else if (strobes.clear || !preDiv)  preCnt <= '0;
        else if (strobes.run)               preCnt <= preCnt + 1'b1;
      end

      assign advance = strobes.run && (!preDiv || preCnt == PRE_MAX);
    end else begin : g_noprescale
      assign advance = strobes.run && !preDiv;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              chainCnt <= '0;
    else if (strobes.clear) chainCnt <= '0;
    else if (advance)       chainCnt <= chainNext;
  end

  assign chainNext = chainCnt + 1'b1;
  assign tapIdx    = TAP_W'(tapIndex(rateSel));
  assign tapEvent  = advance && !chainCnt[tapIdx] && chainNext[tapIdx];

  // R2
  chain_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clear |=> chainCnt == '0);

  // R9
  hold_when_stopped_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.run && !strobes.clear) |=> $stable(chainCnt));

endmodule

// File: rtl/ptg_ctrl.sv
module ptg_ctrl
  import ptg_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        tickEn,
  input  logic        irqEn,
  input  logic        ackWr,
  input  logic        ackVal,
  input  logic        stopMode,
  input  logic        oscInStop,
  input  logic        tapEvent,
  output ctl_strobe_t strobes,
  output logic        eventFlag,
  output logic        irqReq,
  output logic        wakeReq
);

  logic frozen;
  logic ackClear;

  assign frozen        = stopMode && !oscInStop;
  assign strobes.run   = tickEn && !frozen;
  assign strobes.clear = !tickEn;
  assign ackClear      = ackWr && ackVal;

  // Event has priority over the acknowledge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         eventFlag <= 1'b0;
    else if (tapEvent) eventFlag <= 1'b1;
    else if (ackClear) eventFlag <= 1'b0;
  end

  assign irqReq  = eventFlag && irqEn;
  assign wakeReq = irqReq && stopMode;

  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    tapEvent |=> eventFlag);

  // R7
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (eventFlag && !ackClear) |=> eventFlag);

  // R7
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ackClear && !tapEvent) |=> !eventFlag);

  // R6
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (eventFlag && irqEn));

  // R10
  wake_in_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    wakeReq |-> (stopMode && irqReq));

endmodule

// File: rtl/periodic_tick_gen.sv
module periodic_tick_gen
  import ptg_pkg::*;
#(
  parameter int CHAIN_W = 15,
  parameter int PRE_W   = 7
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickEn,
  input  logic       irqEn,
  input  logic [2:0] rateSel,
  input  logic       preDiv,
  input  logic       ackWr,
  input  logic       ackVal,
  input  logic       stopMode,
  input  logic       oscInStop,
  output logic       eventFlag,
  output logic       irqReq,
  output logic       wakeReq
);

  ctl_strobe_t strobes;
  logic        tapEvent;

  ptg_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .tickEn    (tickEn),
    .irqEn     (irqEn),
    .ackWr     (ackWr),
    .ackVal    (ackVal),
    .stopMode  (stopMode),
    .oscInStop (oscInStop),
    .tapEvent  (tapEvent),
    .strobes   (strobes),
    .eventFlag (eventFlag),
    .irqReq    (irqReq),
    .wakeReq   (wakeReq)
  );

  ptg_datapath #(.CHAIN_W(CHAIN_W), .PRE_W(PRE_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .preDiv   (preDiv),
    .rateSel  (rateSel),
    .tapEvent (tapEvent)
  );

endmodule

// File: tb/sim_periodic_tick_gen.sv
module sim_periodic_tick_gen;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b0, irqEn = 1'b0, preDiv = 1'b0;
  logic [2:0] rateSel = 3'd7;
  logic       ackWr = 1'b0, ackVal = 1'b0, stopMode = 1'b0, oscInStop = 1'b0;
  logic       eventFlag, irqReq, wakeReq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  periodic_tick_gen u0 (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .irqEn(irqEn), .rateSel(rateSel),
    .preDiv(preDiv), .ackWr(ackWr), .ackVal(ackVal), .stopMode(stopMode),
    .oscInStop(oscInStop), .eventFlag(eventFlag), .irqReq(irqReq), .wakeReq(wakeReq)
  );

  typedef struct packed {
    logic [2:0] rate;
    logic       pre;
    int         first;
  } vec_t;

  localparam vec_t VEC [10] = '{
    '{3'd0, 1'b0, 16384}, '{3'd1, 1'b0, 4096}, '{3'd2, 1'b0, 1024},
    '{3'd3, 1'b0, 64},    '{3'd4, 1'b0, 32},   '{3'd5, 1'b0, 16},
    '{3'd6, 1'b0, 8},     '{3'd7, 1'b0, 4},    '{3'd3, 1'b1, 8192},
    '{3'd7, 1'b1, 512}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Count edges until eventFlag reads 1; drops any acknowledge after the first edge
  task automatic waitFlag(output int n);
    n = 0;
    do begin
      @(posedge clk);
      @(negedge clk);
      ackWr = 1'b0;
      n++;
    end while (!eventFlag && n < 70000);
  endtask

  // Disable for one edge and clear the flag
  task automatic restart();
    tickEn = 1'b0;
    ackWr  = 1'b1;
    ackVal = 1'b1;
    @(posedge clk);
    @(negedge clk);
    ackWr = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    irqEn = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 flag", int'(eventFlag), 0);
    check("R1 irq", int'(irqReq), 0);
    check("R1 wake", int'(wakeReq), 0);
    rstN = 1'b1;
    @(negedge clk);
    irqEn = 1'b0;

    // R3 R4 R5 vector walk
    foreach (VEC[i]) begin
      restart();
      rateSel = VEC[i].rate;
      preDiv  = VEC[i].pre;
      check(VEC[i].pre ? "R5 cleared" : "R3 cleared", int'(eventFlag), 0);
      tickEn = 1'b1;
      waitFlag(n);
      check(VEC[i].pre ? "R5 first" : "R3 first", n, VEC[i].first);
      ackWr = 1'b1; ackVal = 1'b1;
      waitFlag(n);
      check("R4 period", n, 2 * VEC[i].first);
    end
    preDiv = 1'b0;

    // R6 R7 acknowledge and request qualification
    restart();
    rateSel = 3'd3;
    tickEn = 1'b1;
    waitFlag(n);
    ackWr = 1'b1; ackVal = 1'b0;
    @(posedge clk); @(negedge clk);
    ackWr = 1'b0;
    check("R7 ack0 keeps flag", int'(eventFlag), 1);
    irqEn = 1'b0; #1;
    check("R6 irq masked", int'(irqReq), 0);
    irqEn = 1'b1; #1;
    check("R6 irq set", int'(irqReq), 1);
    check("R10 no wake outside stop", int'(wakeReq), 0);
    @(negedge clk);
    ackWr = 1'b1; ackVal = 1'b1;
    @(posedge clk); @(negedge clk);
    ackWr = 1'b0;
    check("R7 ack1 clears", int'(eventFlag), 0);
    check("R6 irq drops", int'(irqReq), 0);

    // R8 event and acknowledge on the same edge
    restart();
    rateSel = 3'd7;
    tickEn = 1'b1;
    waitFlag(n);
    ackWr = 1'b1; ackVal = 1'b1;
    for (int k = 0; k < 7; k++) begin
      @(posedge clk); @(negedge clk);
      ackWr = 1'b0;
    end
    check("R7 cleared before coincidence", int'(eventFlag), 0);
    ackWr = 1'b1;
    @(posedge clk); @(negedge clk);
    ackWr = 1'b0;
    check("R8 set wins", int'(eventFlag), 1);

    // R2 disable restarts the half-period
    restart();
    tickEn = 1'b1;
    repeat (2) begin @(posedge clk); @(negedge clk); end
    tickEn = 1'b0;
    @(posedge clk); @(negedge clk);
    tickEn = 1'b1;
    waitFlag(n);
    check("R2 restart first", n, 4);

    // R9 frozen during stop
    restart();
    oscInStop = 1'b0;
    stopMode = 1'b1;
    tickEn = 1'b1;
    repeat (20) begin @(posedge clk); @(negedge clk); end
    check("R9 no event in stop", int'(eventFlag), 0);
    stopMode = 1'b0;
    waitFlag(n);
    check("R9 resume first", n, 4);

    // R10 keep counting in stop and wake
    restart();
    oscInStop = 1'b1;
    stopMode = 1'b1;
    irqEn = 1'b1;
    tickEn = 1'b1;
    waitFlag(n);
    check("R10 first in stop", n, 4);
    check("R10 wake", int'(wakeReq), 1);
    stopMode = 1'b0; #1;
    check("R10 wake drops", int'(wakeReq), 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule